// File: doc/BRIEF.md
# Path Overhead Extractor with Integrated Status

This block takes the path-overhead bytes of a cell-carrying frame, one byte per strobe, and does three things with them. Every byte of an aligned frame is copied onto an overhead output bus. The bus has a one-cycle enable, a byte position, the byte itself and a start-of-frame flag. The parity byte is replaced by its error pattern, the XOR of the received byte and the parity computed upstream. Seven overhead fields are integrated: a value is accepted into its status register only after it has persisted across several frames. Each field has a sticky change flag, and the growth/status field also carries an unstable flag. One overhead byte, or a pair of bytes, is routed to a data-link output that feeds a downstream HDLC receiver.

A two-state tracker locates each byte in the frame. ST_WAIT discards bytes until a start-of-frame byte arrives (transition WAIT→COLLECT). ST_COLLECT counts positions 1 to 8 (transition COLLECT→COLLECT on each byte). It returns to ST_WAIT after the last byte (COLLECT→WAIT at end of frame), and also when alignment drops (any→WAIT on loss of alignment). A start-of-frame byte seen during ST_COLLECT restarts the count at position 0 (COLLECT restart).

Top module: `poh_extract`

## Requirements
- R1: Each byte taken in an aligned frame appears on the overhead bus one cycle later: `oh_en`=1, `oh_pos` = position, `oh_byte` = the byte. Positions are 0 Z3, 1 Z2, 2 Z1, 3 F1, 4 B1, 5 G1, 6 M2, 7 M1, 8 C1. `oh_sof` is 1 only with position 0. A byte marked with `in_sof` is position 0, and the following bytes count up from it.
- R2: At position 4, `oh_byte` equals `in_byte ^ bip_calc` instead of the raw byte.
- R3: An integrated field is loaded into its status output after the same value has been received in PERSIST (default 5) consecutive frames. The fields are Z3, Z2, Z1, F1, M2 and M1 (8 bits each) and G1, which uses bits [2:0] of its byte only.
- R4: A change flag is set in the cycle a value is accepted that differs from the held one. Acceptance of the same value leaves the flags unchanged. `chg_flags` bit order is 0 Z3, 1 Z2, 2 Z1, 3 F1, 4 G1, 5 M2, 6 M1.
- R5: A 1 on bit n of `chg_clr` clears change flag n. A new setting in the same cycle takes priority over the clear.
- R6: `g1_unstable` sets after UNSTABLE_LIMIT (default 8) consecutive frames in which the G1 field differs from the preceding frame's G1 field. It clears when a G1 value persists for PERSIST frames.
- R7: `dl_sel` picks the data-link source: 0 F1, 1 M2, 2 M1. The chosen byte is emitted with `dl_valid`=1 one cycle after it is taken.
- R8: With `dl_sel`=3, M2 and M1 are sent as one link of two bytes per frame, M2 first.
- R9: While `aligned`=0, no byte is taken. There is no `oh_en`, no `dl_valid`, and the integration counters do not advance. A byte without `in_sof` that arrives in ST_WAIT is ignored.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aligned | input | 1 | Frame alignment held upstream |
| in_valid | input | 1 | Overhead byte strobe |
| in_sof | input | 1 | Marks the first overhead byte of a frame |
| in_byte | input | 8 | Overhead byte |
| bip_calc | input | 8 | Parity computed over the previous frame |
| dl_sel | input | 2 | Data-link source select |
| chg_clr | input | 7 | Write-one-to-clear strobes for the change flags |
| oh_en | output | 1 | Overhead bus byte enable |
| oh_sof | output | 1 | Overhead bus start of frame |
| oh_pos | output | 4 | Overhead byte position |
| oh_byte | output | 8 | Overhead byte (parity byte as error pattern) |
| dl_valid | output | 1 | Data-link byte strobe |
| dl_byte | output | 8 | Data-link byte |
| z3_val | output | 8 | Accepted Z3 |
| z2_val | output | 8 | Accepted Z2 |
| z1_val | output | 8 | Accepted Z1 |
| f1_val | output | 8 | Accepted F1 |
| g1_val | output | 3 | Accepted G1 status field |
| m2_val | output | 8 | Accepted M2 |
| m1_val | output | 8 | Accepted M1 |
| chg_flags | output | 7 | Sticky change flags |
| g1_unstable | output | 1 | G1 field unstable |

## Verification
If the tracker holds a wrong position or state, the next taken byte shows it one cycle later, either as the wrong `oh_pos`, a missing enable or a data-link byte at the wrong position. A wrong persistence or mismatch count inside an integrator stays hidden until acceptance time. It then shows up as a status value or change flag that arrives one frame early or late. For that reason the bench samples the status outputs both at the frame before the expected acceptance and at the acceptance frame. A held alignment error is checked the same way: the bench proves that a frame received out of alignment neither advances nor restarts the persistence count.

// File: rtl/poh_pkg.sv
package poh_pkg;

    localparam int POH_BYTES = 9;
    localparam int POS_W     = $clog2(POH_BYTES);

    localparam int P_Z3 = 0;
    localparam int P_Z2 = 1;
    localparam int P_Z1 = 2;
    localparam int P_F1 = 3;
    localparam int P_B1 = 4;
    localparam int P_G1 = 5;
    localparam int P_M2 = 6;
    localparam int P_M1 = 7;
    localparam int P_C1 = 8;

    localparam int N_FIELDS = 7;
    localparam int G1_FIELD = 4;
    localparam int G1_BITS  = 3;

    typedef enum logic {
        ST_WAIT    = 1'b0,
        ST_COLLECT = 1'b1
    } trk_state_t;

    typedef enum logic [1:0] {
        DL_F1   = 2'd0,
        DL_M2   = 2'd1,
        DL_M1   = 2'd2,
        DL_PAIR = 2'd3
    } dl_src_t;

    function automatic int field_pos(int f);
        case (f)
            0:       return P_Z3;
            1:       return P_Z2;
            2:       return P_Z1;
            3:       return P_F1;
            4:       return P_G1;
            5:       return P_M2;
            default: return P_M1;
        endcase
    endfunction

    function automatic int field_width(int f);
        return (f == G1_FIELD) ? G1_BITS : 8;
    endfunction

endpackage

// File: rtl/poh_frame_tracker.sv
module poh_frame_tracker
    import poh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             aligned,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic             hit,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LAST = POS_W'(P_C1);

    trk_state_t       state_q, state_d;
    logic [POS_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!aligned) begin
            state_d = ST_WAIT;
            cnt_d   = '0;
        end else if (in_valid) begin
            if (in_sof) begin
                state_d = ST_COLLECT;
                cnt_d   = POS_W'(1);
            end else begin
                unique case (state_q)
                    ST_WAIT: begin
                        state_d = ST_WAIT;
                    end
                    ST_COLLECT: begin
                        if (cnt_q == LAST) begin
                            state_d = ST_WAIT;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        hit = 1'b0;
        pos = in_sof ? '0 : cnt_q;
        unique case (state_q)
            ST_WAIT:    hit = aligned && in_valid && in_sof;
            ST_COLLECT: hit = aligned && in_valid;
        endcase
    end

    AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (pos <= LAST)); // R1

    AST_WAIT_NEEDS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !in_sof) |-> !hit); // R9

endmodule

// File: rtl/poh_integrator.sv
module poh_integrator #(
    parameter int W        = 8,
    parameter int PERSIST  = 5,
    parameter int UNST_LIM = 8,
    parameter bit UNST_EN  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         smp,
    input  logic [W-1:0] val,
    input  logic         clr,
    output logic [W-1:0] acc,
    output logic         chg,
    output logic         unst
);

    localparam int CW = $clog2(PERSIST + 1);
    localparam int MW = $clog2(UNST_LIM + 1);

    logic [W-1:0]  cand_q, acc_q;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          chg_q;
    logic          match, reach;

    always_comb begin
        match = (val == cand_q);
        if (!match)
            cnt_nxt = CW'(1);
        else if (cnt_q == CW'(PERSIST))
            cnt_nxt = cnt_q;
        else
            cnt_nxt = cnt_q + 1'b1;
        reach = smp && (cnt_nxt == CW'(PERSIST))
                    && !(match && cnt_q == CW'(PERSIST));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cand_q <= '0;
            cnt_q  <= '0;
            acc_q  <= '0;
            chg_q  <= 1'b0;
        end else begin
            if (smp) begin
                cand_q <= val;
                cnt_q  <= cnt_nxt;
            end
            if (reach && val != acc_q) begin
                acc_q <= val;
                chg_q <= 1'b1;
            end else if (clr) begin
                chg_q <= 1'b0;
            end
        end
    end

    assign acc = acc_q;
    assign chg = chg_q;

    generate
        if (UNST_EN) begin : g_unst
            logic [MW-1:0] mc_q;
            logic          unst_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mc_q   <= '0;
                    unst_q <= 1'b0;
                end else if (smp) begin
                    if (reach) begin
                        mc_q   <= '0;
                        unst_q <= 1'b0;
                    end else if (match) begin
                        mc_q <= '0;
                    end else begin
                        if (mc_q != MW'(UNST_LIM))
                            mc_q <= mc_q + 1'b1;
                        if (mc_q >= MW'(UNST_LIM - 1))
                            unst_q <= 1'b1;
                    end
                end
            end

            assign unst = unst_q;

            AST_UNST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                reach |=> !unst); // R6
        end else begin : g_no_unst
            assign unst = 1'b0;
        end
    endgenerate

    AST_CHG_ON_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc) |-> chg); // R4

    AST_HOLD_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(smp) |-> $stable(acc)); // R9

endmodule

// File: rtl/poh_dlink_sel.sv
module poh_dlink_sel
    import poh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [POS_W-1:0] pos,
    input  logic [7:0]       in_byte,
    input  logic [1:0]       sel,
    output logic             dl_valid,
    output logic [7:0]       dl_byte
);

    logic want;

    always_comb begin
        want = 1'b0;
        unique case (dl_src_t'(sel))
            DL_F1:   want = (pos == POS_W'(P_F1));
            DL_M2:   want = (pos == POS_W'(P_M2));
            DL_M1:   want = (pos == POS_W'(P_M1));
            DL_PAIR: want = (pos == POS_W'(P_M2)) || (pos == POS_W'(P_M1));
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dl_valid <= 1'b0;
            dl_byte  <= '0;
        end else begin
            dl_valid <= hit && want;
            if (hit && want)
                dl_byte <= in_byte;
        end
    end

    AST_DL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !dl_valid); // R9

endmodule

// File: rtl/poh_extract.sv
module poh_extract
    import poh_pkg::*;
#(
    parameter int PERSIST        = 5,
    parameter int UNSTABLE_LIMIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                aligned,
    input  logic                in_valid,
    input  logic                in_sof,
    input  logic [7:0]          in_byte,
    input  logic [7:0]          bip_calc,
    input  logic [1:0]          dl_sel,
    input  logic [N_FIELDS-1:0] chg_clr,
    output logic                oh_en,
    output logic                oh_sof,
    output logic [POS_W-1:0]    oh_pos,
    output logic [7:0]          oh_byte,
    output logic                dl_valid,
    output logic [7:0]          dl_byte,
    output logic [7:0]          z3_val,
    output logic [7:0]          z2_val,
    output logic [7:0]          z1_val,
    output logic [7:0]          f1_val,
    output logic [G1_BITS-1:0]  g1_val,
    output logic [7:0]          m2_val,
    output logic [7:0]          m1_val,
    output logic [N_FIELDS-1:0] chg_flags,
    output logic                g1_unstable
);

    logic             hit;
    logic [POS_W-1:0] pos;
    logic [N_FIELDS-1:0] unst_v;

    poh_frame_tracker u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .aligned  (aligned),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .hit      (hit),
        .pos      (pos)
    );

    // overhead bus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oh_en   <= 1'b0;
            oh_sof  <= 1'b0;
            oh_pos  <= '0;
            oh_byte <= '0;
        end else begin
            oh_en  <= hit;
            oh_sof <= hit && (pos == POS_W'(P_Z3));
            if (hit) begin
                oh_pos  <= pos;
                oh_byte <= (pos == POS_W'(P_B1)) ? (in_byte ^ bip_calc) : in_byte;
            end
        end
    end

    poh_dlink_sel u_dl (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .pos      (pos),
        .in_byte  (in_byte),
        .sel      (dl_sel),
        .dl_valid (dl_valid),
        .dl_byte  (dl_byte)
    );

    generate
        for (genvar g = 0; g < N_FIELDS; g++) begin : g_fld
            localparam int FW = field_width(g);
            localparam int FP = field_pos(g);
            logic [FW-1:0] acc_w;

            poh_integrator #(
                .W        (FW),
                .PERSIST  (PERSIST),
                .UNST_LIM (UNSTABLE_LIMIT),
                .UNST_EN  (g == G1_FIELD)
            ) u_int (
                .clk   (clk),
                .rst_n (rst_n),
                .smp   (hit && (pos == POS_W'(FP))),
                .val   (in_byte[FW-1:0]),
                .clr   (chg_clr[g]),
                .acc   (acc_w),
                .chg   (chg_flags[g]),
                .unst  (unst_v[g])
            );

            if (g == 0) begin : g_z3
                assign z3_val = acc_w;
            end else if (g == 1) begin : g_z2
                assign z2_val = acc_w;
            end else if (g == 2) begin : g_z1
                assign z1_val = acc_w;
            end else if (g == 3) begin : g_f1
                assign f1_val = acc_w;
            end else if (g == 4) begin : g_g1
                assign g1_val = acc_w;
            end else if (g == 5) begin : g_m2
                assign m2_val = acc_w;
            end else begin : g_m1
                assign m1_val = acc_w;
            end
        end
    endgenerate

    assign g1_unstable = |unst_v;

    AST_OH_QUIET_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !aligned |=> !oh_en); // R9

    AST_SOF_AT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        oh_sof |-> (oh_en && oh_pos == '0)); // R1

    AST_DL_FOLLOWS_OH: assert property (@(posedge clk) disable iff (!rst_n)
        dl_valid |-> (oh_en && oh_byte == dl_byte)); // R7

endmodule

// File: tb/poh_extract_tb.sv
`timescale 1ns/1ps
module poh_extract_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       aligned = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sof = 1'b0;
    logic [7:0] in_byte = '0;
    logic [7:0] bip_calc = '0;
    logic [1:0] dl_sel = '0;
    logic [6:0] chg_clr = '0;
    logic       oh_en, oh_sof, dl_valid, g1_unstable;
    logic [3:0] oh_pos;
    logic [7:0] oh_byte, dl_byte, z3_val, z2_val, z1_val, f1_val, m2_val, m1_val;
    logic [2:0] g1_val;
    logic [6:0] chg_flags;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    poh_extract u_dut (
        .clk(clk), .rst_n(rst_n), .aligned(aligned), .in_valid(in_valid),
        .in_sof(in_sof), .in_byte(in_byte), .bip_calc(bip_calc), .dl_sel(dl_sel),
        .chg_clr(chg_clr), .oh_en(oh_en), .oh_sof(oh_sof), .oh_pos(oh_pos),
        .oh_byte(oh_byte), .dl_valid(dl_valid), .dl_byte(dl_byte),
        .z3_val(z3_val), .z2_val(z2_val), .z1_val(z1_val), .f1_val(f1_val),
        .g1_val(g1_val), .m2_val(m2_val), .m1_val(m1_val),
        .chg_flags(chg_flags), .g1_unstable(g1_unstable)
    );

    // byte p at [p*8 +: 8], parity computed upstream at [79:72]
    localparam logic [79:0] VEC [6] = '{
        80'h5A_C1_71_62_05_B1_F1_13_12_11,
        80'h00_C2_72_63_06_FF_F2_23_22_21,
        80'hFF_C3_73_64_07_00_F3_33_32_31,
        80'h3C_C4_74_65_01_3C_F4_43_42_41,
        80'hA5_C5_75_66_02_5A_F5_53_52_51,
        80'h81_C6_76_67_03_18_F6_63_62_61
    };

    localparam logic [79:0] FI = 80'h00_C1_6D_6C_F5_00_F1_13_12_11;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [79:0] set_g1(input logic [79:0] f, input logic [7:0] g);
        logic [79:0] r = f;
        r[47:40] = g;
        return r;
    endfunction

    function automatic logic [79:0] set_z3(input logic [79:0] f, input logic [7:0] z);
        logic [79:0] r = f;
        r[7:0] = z;
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; in_valid = 0; in_sof = 0; chg_clr = '0; aligned = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [79:0] f, input logic al);
        for (int p = 0; p < 9; p++) begin
            logic [7:0] exp_b;
            bit dl_exp;
            @(negedge clk);
            aligned = al; in_valid = 1'b1; in_sof = (p == 0);
            in_byte = f[p*8 +: 8]; bip_calc = f[79:72];
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0;
            exp_b = (p == 4) ? (f[39:32] ^ f[79:72]) : f[p*8 +: 8];
            dl_exp = al && ((dl_sel == 0 && p == 3) || (dl_sel == 1 && p == 6) ||
                            (dl_sel == 2 && p == 7) || (dl_sel == 3 && (p == 6 || p == 7)));
            if (al) begin
                check(oh_en == 1'b1, "R1 oh_en", oh_en, 1);
                check(oh_pos == p[3:0], "R1 oh_pos", oh_pos, p);
                check(oh_sof == (p == 0), "R1 oh_sof", oh_sof, (p == 0));
                check(oh_byte == exp_b, (p == 4) ? "R2 parity pattern" : "R1 oh_byte",
                      oh_byte, exp_b);
                check(dl_valid == dl_exp, (dl_sel == 3) ? "R8 dl_valid" : "R7 dl_valid",
                      dl_valid, dl_exp);
                if (dl_exp)
                    check(dl_byte == f[p*8 +: 8], (dl_sel == 3) ? "R8 dl_byte" : "R7 dl_byte",
                          dl_byte, f[p*8 +: 8]);
            end else begin
                check(oh_en == 1'b0, "R9 oh_en unaligned", oh_en, 0);
                check(dl_valid == 1'b0, "R9 dl_valid unaligned", dl_valid, 0);
            end
        end
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog act=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // R10 reset state
        @(negedge clk); @(negedge clk);
        check({oh_en, oh_sof, dl_valid, g1_unstable} == 4'b0, "R10 strobes", oh_en, 0);
        check(chg_flags == 7'h0, "R10 chg_flags", chg_flags, 0);
        check({z3_val, z2_val, z1_val, f1_val, m2_val, m1_val, g1_val} == '0,
              "R10 status", z3_val, 0);
        rst_n = 1'b1;
        aligned = 1'b1;

        // R9 stray byte in wait state
        @(negedge clk);
        in_valid = 1'b1; in_sof = 1'b0; in_byte = 8'h77;
        @(negedge clk);
        in_valid = 1'b0;
        check(oh_en == 1'b0, "R9 stray byte", oh_en, 0);

        // table walk: R1 R2 R7 R8
        for (int i = 0; i < 6; i++) begin
            dl_sel = 2'(i % 4);
            send_frame(VEC[i], 1'b1);
        end
        dl_sel = 2'd3;
        send_frame(VEC[0], 1'b1);

        // R3 persistence
        do_reset();
        for (int k = 0; k < 4; k++) send_frame(FI, 1'b1);
        check(z3_val == 8'h00, "R3 early z3", z3_val, 0);
        check(chg_flags == 7'h00, "R3 early chg", chg_flags, 0);
        send_frame(FI, 1'b1);
        check(z3_val == 8'h11 && z2_val == 8'h12 && z1_val == 8'h13, "R3 z fields", z3_val, 8'h11);
        check(f1_val == 8'hF1, "R3 f1", f1_val, 8'hF1);
        check(g1_val == 3'd5, "R3 g1 low bits", g1_val, 5);
        check(m2_val == 8'h6C && m1_val == 8'h6D, "R3 m fields", m2_val, 8'h6C);
        check(chg_flags == 7'h7F, "R4 all changed", chg_flags, 8'h7F);

        // R5 clear
        @(negedge clk); chg_clr = 7'h05;
        @(negedge clk); chg_clr = 7'h00;
        check(chg_flags == 7'h7A, "R5 w1c", chg_flags, 8'h7A);

        // R4 same value re-accepted
        for (int k = 0; k < 5; k++) send_frame(FI, 1'b1);
        check(chg_flags == 7'h7A, "R4 same value no flag", chg_flags, 8'h7A);
        for (int k = 0; k < 4; k++) send_frame(set_z3(FI, 8'h22), 1'b1);
        check(z3_val == 8'h11, "R4 z3 pending", z3_val, 8'h11);
        send_frame(set_z3(FI, 8'h22), 1'b1);
        check(z3_val == 8'h22, "R4 z3 new", z3_val, 8'h22);
        check(chg_flags == 7'h7B, "R4 z3 flag", chg_flags, 8'h7B);

        // R6 unstable
        do_reset();
        for (int k = 0; k < 7; k++) send_frame(set_g1(FI, 8'((k % 7) + 1)), 1'b1);
        check(g1_unstable == 1'b0, "R6 not yet unstable", g1_unstable, 0);
        send_frame(set_g1(FI, 8'h01), 1'b1);
        check(g1_unstable == 1'b1, "R6 unstable", g1_unstable, 1);
        for (int k = 0; k < 4; k++) send_frame(set_g1(FI, 8'h02), 1'b1);
        check(g1_unstable == 1'b1, "R6 still unstable", g1_unstable, 1);
        send_frame(set_g1(FI, 8'h02), 1'b1);
        check(g1_unstable == 1'b0, "R6 cleared", g1_unstable, 0);
        check(g1_val == 3'd2, "R6 g1 accepted", g1_val, 2);

        // R9 unaligned frame does not count
        do_reset();
        for (int k = 0; k < 4; k++) send_frame(FI, 1'b1);
        send_frame(FI, 1'b0);
        check(z3_val == 8'h00, "R9 no integration unaligned", z3_val, 0);
        send_frame(FI, 1'b1);
        check(z3_val == 8'h11, "R9 count held", z3_val, 8'h11);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule